// File: doc/BRIEF.md
# State-Indexed Multi-Byte Transition Cache

This block lets a string-matching automaton skip its one-byte transition engine when it sits in any state other than the root. Each lookup presents the current state number and a window of the next few text bytes. The cache is direct-mapped. The low bits of the state number select a line. That line holds a tag, a next state and a match length. The tag is made of the remaining state bits and the text bytes that were seen when the line was installed. A hit gives the next state straight from the line and moves the text pointer forward by the stored length, so one step can consume several characters. A miss gives the one-byte engine's answer and a step of one byte.

The engine sits outside the block. The block presents the current state and the first window byte on a query port and takes the engine's answer back in the same cycle. A separate write port installs a line whenever the external update decision approves one. Results appear one cycle after the request.

A small response machine holds the outcome of the previous cycle. It has four states:
- IDLE: no request.
- ROOT: the request was at the root state, so the engine answer is used.
- MISS: the cache missed, so the engine answer is used.
- HIT: the line supplied the answer.

Every clock edge moves the machine to the state that matches the current request: to IDLE when the request strobe is low, to ROOT when the state is the root, and otherwise to HIT or MISS as decided by the tag compare. Any state can move to any of the four.

Top module: `trans_cache`

## Requirements
- R1: After reset, every line is invalid and `rsp_valid` is 0. A lookup at a non-root state that has not been written since reset misses.
- R2: A lookup at a non-root state that matches a valid line with a length from 1 to WIN_BYTES returns the result in the next cycle. In that result `rsp_valid`=1, `rsp_hit`=1, `rsp_next` is the line's next state and `rsp_adv` is the line's length.
- R3: A lookup at a non-root state that misses returns, one cycle later, `rsp_hit`=0, `rsp_adv`=1 and `rsp_next` equal to the `eng_next` value present in the request cycle.
- R4: A lookup at the root state (state number 0) never hits, even if a line was written for that state. It returns the engine answer and `rsp_adv`=1.
- R5: The line index is state bits [IDX_W-1:0]. The tag holds state bits [STATE_W-1:IDX_W]. Two states with the same low bits share one line, and the later write replaces the earlier one.
- R6: Byte k of a window is bits [8k+7:8k], and byte 0 is the next text byte. A hit needs only bytes 0 to len-1 of the lookup window to equal the stored bytes. Bytes at or beyond the length have no effect.
- R7: A line written with length 0 always misses. A write with a length greater than WIN_BYTES is dropped, and the line keeps its previous content.
- R8: A write and a lookup to the same line in the same cycle: the lookup sees the line as it was before the write. The next lookup sees the new content.
- R9: `rsp_valid` in a cycle equals `lk_valid` in the cycle before. When `lk_valid` is 0, no result is produced.
- R10: `eng_state` equals `lk_state` and `eng_byte` equals `lk_win[7:0]` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_state | input | STATE_W | Current automaton state |
| lk_win | input | 8*WIN_BYTES | Upcoming text bytes, byte 0 in the low bits |
| eng_state | output | STATE_W | State presented to the one-byte engine |
| eng_byte | output | 8 | Byte presented to the one-byte engine |
| eng_next | input | STATE_W | Engine's next state for the presented query |
| wr_en | input | 1 | Install a line |
| wr_state | input | STATE_W | State the line belongs to |
| wr_win | input | 8*WIN_BYTES | Text bytes that led to the new state |
| wr_next | input | STATE_W | Next state to store |
| wr_len | input | LEN_W | Number of bytes the line consumes |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Result came from the cache |
| rsp_next | output | STATE_W | Next automaton state |
| rsp_adv | output | LEN_W | Bytes to advance the text pointer |

## Verification
The assertions assume that `eng_next` settles within the same cycle as the query that produces it. They also assume that the root state is number 0. The bench meets the first assumption by driving the engine answer as a pure combinational function of `eng_state` and `eng_byte`. Random stimulus draws states from a few tag values and a few indices, so the root, conflicting lines and repeated lines all occur often. Windows are built from two byte values so that partial-window matches occur. Write lengths cover 0 to 7, which includes the zero-length and over-length cases the requirements describe.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_ROOT = 2'd1,
        RS_MISS = 2'd2,
        RS_HIT  = 2'd3
    } rsp_state_e;
endpackage

// File: rtl/tc_key_split.sv
// Splits a state into line index and upper tag bits, and zeroes window bytes
// at or beyond the given length so tags compare over the consumed bytes only.
module tc_key_split #(
    parameter int STATE_W   = 24,
    parameter int IDX_W     = 12,
    parameter int WIN_BYTES = 4,
    parameter int LEN_W     = 3,
    localparam int HI_W     = STATE_W - IDX_W,
    localparam int WIN_W    = 8 * WIN_BYTES
) (
    input  logic [STATE_W-1:0] state,
    input  logic [WIN_W-1:0]   win,
    input  logic [LEN_W-1:0]   len,
    output logic [IDX_W-1:0]   idx,
    output logic [HI_W-1:0]    hi,
    output logic [WIN_W-1:0]   win_m
);
    assign idx = state[IDX_W-1:0];
    assign hi  = state[STATE_W-1:IDX_W];

    for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
        assign win_m[8*b +: 8] = (len > LEN_W'(b)) ? win[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/tc_entry_store.sv
// Direct-mapped line storage: valid bits under reset, data arrays without.
module tc_entry_store #(
    parameter int STATE_W   = 24,
    parameter int IDX_W     = 12,
    parameter int WIN_BYTES = 4,
    parameter int LEN_W     = 3,
    localparam int HI_W     = STATE_W - IDX_W,
    localparam int WIN_W    = 8 * WIN_BYTES,
    localparam int DEPTH    = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [HI_W-1:0]    rd_hi,
    output logic [WIN_W-1:0]   rd_win,
    output logic [STATE_W-1:0] rd_next,
    output logic [LEN_W-1:0]   rd_len,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [HI_W-1:0]    wr_hi,
    input  logic [WIN_W-1:0]   wr_win,
    input  logic [STATE_W-1:0] wr_next,
    input  logic [LEN_W-1:0]   wr_len
);
    logic [DEPTH-1:0]   vld_q;
    logic [HI_W-1:0]    hi_mem  [DEPTH];
    logic [WIN_W-1:0]   win_mem [DEPTH];
    logic [STATE_W-1:0] ns_mem  [DEPTH];
    logic [LEN_W-1:0]   len_mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            hi_mem[wr_idx]  <= wr_hi;
            win_mem[wr_idx] <= wr_win;
            ns_mem[wr_idx]  <= wr_next;
            len_mem[wr_idx] <= wr_len;
        end
    end

    // Asynchronous read: a same-cycle write lands only at the edge (R8).
    assign rd_valid = vld_q[rd_idx];
    assign rd_hi    = hi_mem[rd_idx];
    assign rd_win   = win_mem[rd_idx];
    assign rd_next  = ns_mem[rd_idx];
    assign rd_len   = len_mem[rd_idx];

    // The top filters over-length writes before they reach the store.
    assert_store_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_len <= LEN_W'(WIN_BYTES)));

    // An installed line reads back valid on the following cycle.
    assert_store_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rd_idx == wr_idx)) |=> rd_valid || (rd_idx != $past(wr_idx)));
endmodule

// File: rtl/trans_cache.sv
module trans_cache #(
    parameter int STATE_W    = 24,
    parameter int IDX_W      = 12,
    parameter int WIN_BYTES  = 4,
    parameter int LEN_W      = 3,
    parameter logic [STATE_W-1:0] ROOT_STATE = '0,
    localparam int HI_W      = STATE_W - IDX_W,
    localparam int WIN_W     = 8 * WIN_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [STATE_W-1:0] lk_state,
    input  logic [WIN_W-1:0]   lk_win,
    output logic [STATE_W-1:0] eng_state,
    output logic [7:0]         eng_byte,
    input  logic [STATE_W-1:0] eng_next,
    input  logic               wr_en,
    input  logic [STATE_W-1:0] wr_state,
    input  logic [WIN_W-1:0]   wr_win,
    input  logic [STATE_W-1:0] wr_next,
    input  logic [LEN_W-1:0]   wr_len,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [STATE_W-1:0] rsp_next,
    output logic [LEN_W-1:0]   rsp_adv
);
    import tc_pkg::*;

    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(WIN_BYTES);

    // Engine query is a straight pass-through (R10).
    assign eng_state = lk_state;
    assign eng_byte  = lk_win[7:0];

    // ---------------- write path ----------------
    logic               wr_ok;
    logic [IDX_W-1:0]   wr_idx;
    logic [HI_W-1:0]    wr_hi;
    logic [WIN_W-1:0]   wr_win_m;

    assign wr_ok = wr_en && (wr_len <= MAX_LEN);

    tc_key_split #(.STATE_W(STATE_W), .IDX_W(IDX_W), .WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W))
    u_wr_key (
        .state (wr_state),
        .win   (wr_win),
        .len   (wr_len),
        .idx   (wr_idx),
        .hi    (wr_hi),
        .win_m (wr_win_m)
    );

    // ---------------- lookup path ----------------
    logic               rd_valid;
    logic [HI_W-1:0]    rd_hi;
    logic [WIN_W-1:0]   rd_win;
    logic [STATE_W-1:0] rd_next;
    logic [LEN_W-1:0]   rd_len;
    logic [IDX_W-1:0]   lk_idx;
    logic [HI_W-1:0]    lk_hi;
    logic [WIN_W-1:0]   lk_win_m;

    tc_key_split #(.STATE_W(STATE_W), .IDX_W(IDX_W), .WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W))
    u_lk_key (
        .state (lk_state),
        .win   (lk_win),
        .len   (rd_len),
        .idx   (lk_idx),
        .hi    (lk_hi),
        .win_m (lk_win_m)
    );

    tc_entry_store #(.STATE_W(STATE_W), .IDX_W(IDX_W), .WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W))
    u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_valid (rd_valid),
        .rd_hi    (rd_hi),
        .rd_win   (rd_win),
        .rd_next  (rd_next),
        .rd_len   (rd_len),
        .wr_en    (wr_ok),
        .wr_idx   (wr_idx),
        .wr_hi    (wr_hi),
        .wr_win   (wr_win_m),
        .wr_next  (wr_next),
        .wr_len   (wr_len)
    );

    logic tag_hit;
    assign tag_hit = rd_valid && (rd_len != '0) && (rd_len <= MAX_LEN)
                     && (rd_hi == lk_hi) && (rd_win == lk_win_m);

    // ---------------- response state machine ----------------
    rsp_state_e         st_q, st_d;
    logic [STATE_W-1:0] ns_q;
    logic [LEN_W-1:0]   len_q;

    always_comb begin
        if (!lk_valid)                   st_d = RS_IDLE;
        else if (lk_state == ROOT_STATE) st_d = RS_ROOT;
        else if (tag_hit)                st_d = RS_HIT;
        else                             st_d = RS_MISS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RS_IDLE;
            ns_q  <= '0;
            len_q <= '0;
        end else begin
            st_q <= st_d;
            if (lk_valid) begin
                ns_q  <= (st_d == RS_HIT) ? rd_next : eng_next;
                len_q <= rd_len;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            RS_IDLE: begin
                rsp_valid = 1'b0; rsp_hit = 1'b0; rsp_adv = '0;
            end
            RS_ROOT, RS_MISS: begin
                rsp_valid = 1'b1; rsp_hit = 1'b0; rsp_adv = LEN_W'(1);
            end
            RS_HIT: begin
                rsp_valid = 1'b1; rsp_hit = 1'b1; rsp_adv = len_q;
            end
            default: begin
                rsp_valid = 1'b0; rsp_hit = 1'b0; rsp_adv = '0;
            end
        endcase
        rsp_next = ns_q;
    end

    // ---------------- assertions ----------------
    assert_hit_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_adv != '0) && (rsp_adv <= MAX_LEN));

    assert_miss_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_adv == LEN_W'(1)));

    assert_miss_engine_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !tag_hit) |=> (rsp_next == $past(eng_next)));

    assert_root_nohit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (lk_state == ROOT_STATE)) |=> (rsp_valid && !rsp_hit));

    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_idle_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (rd_len == '0)) |=> !rsp_hit);
endmodule

// File: tb/tb_trans_cache.sv
module tb_trans_cache;
    localparam int SW = 24;
    localparam int IW = 12;
    localparam int WB = 4;
    localparam int LW = 3;
    localparam int WW = 8 * WB;
    localparam int DEPTH = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [SW-1:0] lk_state = '0;
    logic [WW-1:0] lk_win = '0;
    logic [SW-1:0] eng_state;
    logic [7:0]    eng_byte;
    logic [SW-1:0] eng_next;
    logic          wr_en = 1'b0;
    logic [SW-1:0] wr_state = '0;
    logic [WW-1:0] wr_win = '0;
    logic [SW-1:0] wr_next = '0;
    logic [LW-1:0] wr_len = '0;
    logic          rsp_valid, rsp_hit;
    logic [SW-1:0] rsp_next;
    logic [LW-1:0] rsp_adv;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    trans_cache dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_state(lk_state), .lk_win(lk_win),
        .eng_state(eng_state), .eng_byte(eng_byte), .eng_next(eng_next),
        .wr_en(wr_en), .wr_state(wr_state), .wr_win(wr_win), .wr_next(wr_next), .wr_len(wr_len),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_next(rsp_next), .rsp_adv(rsp_adv)
    );

    function automatic logic [SW-1:0] eng_fn(input logic [SW-1:0] s, input logic [7:0] b);
        return s * 24'd37 + {16'd0, b} * 24'd1031 + 24'h5A5;
    endfunction

    assign eng_next = eng_fn(eng_state, eng_byte);

    // Reference model of the lines
    bit            m_v   [DEPTH];
    logic [SW-IW-1:0] m_hi [DEPTH];
    logic [WW-1:0] m_win [DEPTH];
    logic [SW-1:0] m_ns  [DEPTH];
    logic [LW-1:0] m_len [DEPTH];

    function automatic logic [WW-1:0] mask_of(input logic [LW-1:0] len);
        logic [WW-1:0] m = '0;
        for (int b = 0; b < WB; b++) if (b < int'(len)) m[8*b +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive lookup and write, check engine port, then the result.
    task automatic step(input string tag, input bit lv, input logic [SW-1:0] ls, input logic [WW-1:0] lw,
                        input bit we, input logic [SW-1:0] ws, input logic [WW-1:0] ww,
                        input logic [SW-1:0] wn, input logic [LW-1:0] wl);
        int i;
        bit e_hit;
        logic [SW-1:0] e_ns;
        logic [LW-1:0] e_adv;
        lk_valid = lv; lk_state = ls; lk_win = lw;
        wr_en = we; wr_state = ws; wr_win = ww; wr_next = wn; wr_len = wl;
        i = int'(ls[IW-1:0]);
        e_hit = (ls != '0) && m_v[i] && (m_len[i] != '0) && (m_hi[i] == ls[SW-1:IW])
                && ((lw & mask_of(m_len[i])) == m_win[i]);
        e_ns  = e_hit ? m_ns[i] : eng_fn(ls, lw[7:0]);
        e_adv = e_hit ? m_len[i] : LW'(1);
        #1;
        if (lv) begin
            check("R10", "eng_state", 32'(eng_state), 32'(ls));
            check("R10", "eng_byte", 32'(eng_byte), 32'(lw[7:0]));
        end
        if (we && wl <= LW'(WB)) begin
            i = int'(ws[IW-1:0]);
            m_v[i] = 1'b1; m_hi[i] = ws[SW-1:IW]; m_win[i] = ww & mask_of(wl);
            m_ns[i] = wn; m_len[i] = wl;
        end
        @(negedge clk);
        check(lv ? tag : "R9", "rsp_valid", 32'(rsp_valid), 32'(lv));
        if (lv) begin
            check(tag, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
            check(tag, "rsp_next", 32'(rsp_next), 32'(e_ns));
            check(tag, "rsp_adv", 32'(rsp_adv), 32'(e_adv));
        end
    endtask

    task automatic look(input string tag, input logic [SW-1:0] s, input logic [WW-1:0] w);
        step(tag, 1'b1, s, w, 1'b0, '0, '0, '0, '0);
    endtask

    task automatic put(input logic [SW-1:0] s, input logic [WW-1:0] w, input logic [SW-1:0] n, input logic [LW-1:0] l);
        step("R9", 1'b0, '0, '0, 1'b1, s, w, n, l);
    endtask

    function automatic logic [SW-1:0] rnd_state();
        return {12'($urandom % 3), 12'($urandom % 8)};
    endfunction

    function automatic logic [WW-1:0] rnd_win();
        logic [WW-1:0] w;
        for (int b = 0; b < WB; b++) w[8*b +: 8] = ($urandom % 2 == 0) ? 8'h41 : 8'h42;
        return w;
    endfunction

    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            m_v[k] = 1'b0; m_hi[k] = '0; m_win[k] = '0; m_ns[k] = '0; m_len[k] = '0;
        end
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        check("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);

        look("R1", 24'h001005, 32'h44434241);                  // cold miss
        put(24'h001005, 32'h44434241, 24'h0ABCDE, 3'd3);
        look("R6", 24'h001005, 32'h99434241);                  // byte 3 ignored -> hit
        look("R2", 24'h001005, 32'h44434241);
        look("R3", 24'h001005, 32'h44434240);                  // byte 0 differs -> miss
        put(24'h002005, 32'h00000041, 24'h012345, 3'd1);       // same index, evicts
        look("R5", 24'h001005, 32'h44434241);
        look("R5", 24'h002005, 32'h77777741);
        put(24'h001007, 32'h41414141, 24'h00BEEF, 3'd0);       // zero length
        look("R7", 24'h001007, 32'h41414141);
        put(24'h002005, 32'h41414141, 24'h0FFFFF, 3'd5);       // over length, dropped
        look("R7", 24'h002005, 32'h00000041);
        step("R8", 1'b1, 24'h003009, 32'h42424242, 1'b1, 24'h003009, 32'h42424242, 24'h055555, 3'd4);
        look("R8", 24'h003009, 32'h42424242);
        put(24'h000000, 32'h41414141, 24'h066666, 3'd2);       // line for root
        look("R4", 24'h000000, 32'h41414141);
        step("R9", 1'b0, 24'h003009, 32'h42424242, 1'b0, '0, '0, '0, '0);

        for (int n = 0; n < 3000; n++) begin
            logic [SW-1:0] s;
            logic [WW-1:0] w;
            string tg;
            s = rnd_state();
            w = rnd_win();
            tg = (s == '0) ? "R4" : "R2";
            step(tg, ($urandom % 8) != 0, s, w, ($urandom % 3) == 0, rnd_state(), rnd_win(),
                 24'($urandom), 3'($urandom % 8));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule